// File: doc/BRIEF.md
# Low-Power Mode Sequencer with DMA Partial Wakeup

This block moves a microcontroller-style system from its running state into one of four low-power modes, and back out again. Entering a mode follows a fixed order. Bus masters are asked to stop first. Bus slaves are asked to stop once the masters acknowledge. After that the clocks are gated, and for the two deep modes the clock generator and the voltage regulator are asked to enter their low-power states. Every step waits for the matching acknowledge. Leaving a mode on an interrupt runs the same steps in reverse: regulator, then clock generator, then system and bus clocks, then release of the stop requests, and finally the core clock.

A DMA channel whose wakeup enable is set can raise its request while the system sleeps. This causes a partial wakeup. The regulator and clock generator are restored if needed, the system and bus clocks run, and the stop requests are released, but the core clock stays off. In Compute mode the core clock stays on throughout. The mode that was left is held in a register. Once the waking request has dropped and the DMA engine reports that it is idle, the block goes back into that same mode, using the normal entry order.

All control and status pins are plain levels. No pin carries a data stream, so there is no valid/ready handshake. The interrupt and DMA request inputs are asynchronous and pass through synchronizers inside the block.

Top module: `lpm_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it rises, the outputs show Run. Core, system and bus clock enables are 1, and every stop request and low-power request is 0. Reset aborts any sequence at once.
- R2: In Run, a one-cycle `mode_go` with `mode_req` set to 1 (Compute), 2 (partial stop), 3 (Stop) or 4 (very-low-power Stop) starts entry into that mode. Codes 0, 5, 6 and 7 are ignored. `slv_stop_req` rises only after `mst_stop_ack` has been sampled high. Clocks are gated only after `slv_stop_ack` has been sampled high.
- R3: Once settled in partial stop, all three clock enables are 0 and both stop requests are 1. `clkgen_lp_req`, `reg_lp_req` and `reg_vlp_req` are 0.
- R4: Once settled in Stop, the pattern is that of R3 with `clkgen_lp_req` = 1 and `reg_lp_req` = 1 added. Very-low-power Stop also sets `reg_vlp_req` = 1. These requests are never high while a clock runs or a stop request is low.
- R5: Once settled in Compute, `core_clk_en` = 1, the system and bus clocks are off, both stop requests are 1, and every low-power request is 0.
- R6: A synchronized `irq_async` in any settled low-power mode leads back to Run. From a deep mode the exit order is: `reg_lp_req` drops and the block waits for `reg_ready`. Then `clkgen_lp_req` drops and the block waits for `clkgen_stable`. Only then do the clocks start and the stop requests release.
- R7: Only the request of a channel whose bit in `dma_wake_en` is 1 can wake the block. A request on a disabled channel leaves the outputs unchanged.
- R8: An enabled DMA wakeup turns on the system and bus clocks and releases both stop requests, in the same order as R6. The core clock stays 0, except in Compute, where it stays 1.
- R9: The partial wakeup persists until the enabled requests are all low and `dma_idle` is 1. The block then re-enters the mode recorded at entry: masters first, then slaves, then, for Stop and very-low-power Stop, the clock generator and regulator low-power requests.
- R10: A synchronized interrupt during a DMA partial wakeup ends it in Run, with the core clock on.
- R11: `irq_async` and `dma_req_async` pass through a two-flop synchronizer. A change on either input does not alter any output until at least two clock edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 3 | Requested low-power mode code |
| mode_go | input | 1 | Start entry into `mode_req` (honoured in Run only) |
| irq_async | input | 1 | Asynchronous wake interrupt from any master or slave |
| dma_req_async | input | DMA_CH | Asynchronous DMA requests, one per channel |
| dma_wake_en | input | DMA_CH | Wakeup enable, one per channel |
| dma_idle | input | 1 | DMA engine has no transfer in progress |
| mst_stop_ack | input | 1 | All non-CPU bus masters have stopped |
| slv_stop_ack | input | 1 | All bus slaves have stopped |
| reg_ready | input | 1 | Regulator and power switches are at full-power level |
| clkgen_stable | input | 1 | Clock generator outputs are running and stable |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| mst_stop_req | output | 1 | Stop request to bus masters |
| slv_stop_req | output | 1 | Stop request to bus slaves |
| clkgen_lp_req | output | 1 | Clock generator low-power request |
| reg_lp_req | output | 1 | Regulator low-power request |
| reg_vlp_req | output | 1 | Regulator very-low-power level select |

## Verification
The assertions assume the following about the block's inputs. Each acknowledge follows its request and is never raised before the request appears. `reg_ready` falls while the regulator is in low power and rises after that request is withdrawn, and `clkgen_stable` tracks the clock generator request in the same way. The bench meets these assumptions with a falling-edge responder that derives every acknowledge from the block's own requests. It can freeze the master/slave acknowledges or the regulator acknowledge, which holds a sequence at one step so the step order can be observed. Wakeup enables are changed only while no enabled request is pending, and `mode_go` is pulsed only while the outputs show Run.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    MODE_RUN     = 3'd0,
    MODE_COMPUTE = 3'd1,
    MODE_PSTOP   = 3'd2,
    MODE_STOP    = 3'd3,
    MODE_VLPS    = 3'd4
  } lp_mode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_MST,
    ST_SLV,
    ST_SLEEP,
    ST_WREG,
    ST_WCLK,
    ST_DMA
  } seq_state_e;

  function automatic logic mode_is_deep(lp_mode_e m);
    return (m == MODE_STOP) || (m == MODE_VLPS);
  endfunction

  function automatic logic mode_code_ok(logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

  // R11: a change on the output was already present on the previous stage one edge earlier
  assert_sync_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> (q == $past(stage_q[STAGES-2])));
endmodule

// File: rtl/lpm_dma_wake.sv
module lpm_dma_wake #(
  parameter int CH = 4
) (
  input  logic [CH-1:0] req_sync,
  input  logic [CH-1:0] wake_en,
  output logic          hit
);
  logic [CH-1:0] masked;

  genvar c;
  for (c = 0; c < CH; c++) begin : g_chan
    assign masked[c] = req_sync[c] & wake_en[c];
  end

  assign hit = |masked;

  // R7: a wake hit always traces back to at least one enabled channel
  always_comb begin
    assert_hit_enabled_R7: assert (!hit || ((req_sync & wake_en) != '0));
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int DMA_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_req,
  input  logic              mode_go,
  input  logic              irq_async,
  input  logic [DMA_CH-1:0] dma_req_async,
  input  logic [DMA_CH-1:0] dma_wake_en,
  input  logic              dma_idle,
  input  logic              mst_stop_ack,
  input  logic              slv_stop_ack,
  input  logic              reg_ready,
  input  logic              clkgen_stable,
  output logic              core_clk_en,
  output logic              sys_clk_en,
  output logic              bus_clk_en,
  output logic              mst_stop_req,
  output logic              slv_stop_req,
  output logic              clkgen_lp_req,
  output logic              reg_lp_req,
  output logic              reg_vlp_req
);
  localparam int SYNC_W = DMA_CH + 1;

  logic [SYNC_W-1:0] sync_q;
  logic              irq_s;
  logic [DMA_CH-1:0] dma_req_s;
  logic              dma_hit;

  lpm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({irq_async, dma_req_async}),
    .q     (sync_q)
  );

  assign irq_s     = sync_q[SYNC_W-1];
  assign dma_req_s = sync_q[DMA_CH-1:0];

  lpm_dma_wake #(.CH(DMA_CH)) u_wake (
    .req_sync (dma_req_s),
    .wake_en  (dma_wake_en),
    .hit      (dma_hit)
  );

  seq_state_e state_q, state_d;
  lp_mode_e   tgt_q;
  logic       dma_wake_q;
  logic       deep;

  assign deep = mode_is_deep(tgt_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (mode_go && mode_code_ok(mode_req)) state_d = ST_MST;
      ST_MST:   if (mst_stop_ack) state_d = ST_SLV;
      ST_SLV:   if (slv_stop_ack) state_d = ST_SLEEP;
      ST_SLEEP: if (irq_s || dma_hit) begin
                  if (deep)       state_d = ST_WREG;
                  else if (irq_s) state_d = ST_RUN;
                  else            state_d = ST_DMA;
                end
      ST_WREG:  if (reg_ready) state_d = ST_WCLK;
      ST_WCLK:  if (clkgen_stable) state_d = dma_wake_q ? ST_DMA : ST_RUN;
      ST_DMA:   if (irq_s) state_d = ST_RUN;
                else if (!dma_hit && dma_idle) state_d = ST_MST;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      tgt_q      <= MODE_RUN;
      dma_wake_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && state_d == ST_MST) tgt_q <= lp_mode_e'(mode_req);
      if (state_d == ST_RUN) dma_wake_q <= 1'b0;
      else if (state_q == ST_SLEEP && state_d != ST_SLEEP) dma_wake_q <= !irq_s;
    end
  end

  logic bus_up, stopping;
  assign bus_up   = (state_q == ST_RUN) || (state_q == ST_MST) ||
                    (state_q == ST_SLV) || (state_q == ST_DMA);
  assign stopping = (state_q == ST_SLEEP) || (state_q == ST_WREG) || (state_q == ST_WCLK);

  assign core_clk_en   = (state_q == ST_RUN) || (tgt_q == MODE_COMPUTE) ||
                         (((state_q == ST_MST) || (state_q == ST_SLV)) && !dma_wake_q);
  assign sys_clk_en    = bus_up;
  assign bus_clk_en    = bus_up;
  assign mst_stop_req  = (state_q == ST_MST) || (state_q == ST_SLV) || stopping;
  assign slv_stop_req  = (state_q == ST_SLV) || stopping;
  assign clkgen_lp_req = deep && ((state_q == ST_SLEEP) || (state_q == ST_WREG));
  assign reg_lp_req    = deep && (state_q == ST_SLEEP);
  assign reg_vlp_req   = (tgt_q == MODE_VLPS) && (state_q == ST_SLEEP);

  // R2: slaves are asked to stop only after the masters acknowledged
  assert_slv_after_mst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slv_stop_req) |-> $past(mst_stop_ack));

  // R4: low-power requests only with clocks gated and everything stopped
  assert_lp_only_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_lp_req || clkgen_lp_req) |-> (mst_stop_req && slv_stop_req && !sys_clk_en && !bus_clk_en));

  // R6: clock generator leaves low power only after the regulator reported ready
  assert_clkgen_after_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkgen_lp_req) |-> ($past(reg_ready) && !reg_lp_req));

  // R8: stop requests release only with system and bus clocks already running
  assert_release_after_clocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_stop_req) |-> (sys_clk_en && bus_clk_en && !clkgen_lp_req && !reg_lp_req));

  // R10: the core clock never restarts while masters are still asked to stop
  assert_core_start_after_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> (!mst_stop_req && sys_clk_en));
endmodule

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;
  localparam int CH = 4;

  localparam logic [7:0] P_RUN   = 8'b1110_0000;
  localparam logic [7:0] P_MSTW  = 8'b1111_0000;
  localparam logic [7:0] P_CMP   = 8'b1001_1000;
  localparam logic [7:0] P_PSTOP = 8'b0001_1000;
  localparam logic [7:0] P_STOP  = 8'b0001_1110;
  localparam logic [7:0] P_VLPS  = 8'b0001_1111;
  localparam logic [7:0] P_REGUP = 8'b0001_1100;
  localparam logic [7:0] P_DMA   = 8'b0110_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_req = 3'd0;
  logic mode_go = 1'b0;
  logic irq_async = 1'b0;
  logic [CH-1:0] dma_req_async = '0;
  logic [CH-1:0] dma_wake_en = '0;
  logic dma_idle = 1'b1;
  logic mst_stop_ack = 1'b0, slv_stop_ack = 1'b0;
  logic reg_ready = 1'b1, clkgen_stable = 1'b1;
  logic core_clk_en, sys_clk_en, bus_clk_en, mst_stop_req, slv_stop_req;
  logic clkgen_lp_req, reg_lp_req, reg_vlp_req;

  logic resp_bus_en = 1'b1;
  logic resp_reg_en = 1'b1;
  int   n_checks = 0;
  int   n_fail = 0;

  always #4 clk = ~clk;

  lpm_sequencer #(.DMA_CH(CH), .SYNC_STAGES(2)) u_lpm_sequencer (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_go(mode_go),
    .irq_async(irq_async), .dma_req_async(dma_req_async), .dma_wake_en(dma_wake_en),
    .dma_idle(dma_idle), .mst_stop_ack(mst_stop_ack), .slv_stop_ack(slv_stop_ack),
    .reg_ready(reg_ready), .clkgen_stable(clkgen_stable),
    .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .bus_clk_en(bus_clk_en),
    .mst_stop_req(mst_stop_req), .slv_stop_req(slv_stop_req),
    .clkgen_lp_req(clkgen_lp_req), .reg_lp_req(reg_lp_req), .reg_vlp_req(reg_vlp_req)
  );

  // acknowledge model, updated away from the active edge
  always @(negedge clk) begin
    mst_stop_ack  = resp_bus_en ? mst_stop_req : 1'b0;
    slv_stop_ack  = resp_bus_en ? slv_stop_req : 1'b0;
    if (resp_reg_en) reg_ready = !reg_lp_req;
    clkgen_stable = !clkgen_lp_req;
  end

  function automatic logic [7:0] outs();
    return {core_clk_en, sys_clk_en, bus_clk_en, mst_stop_req, slv_stop_req,
            clkgen_lp_req, reg_lp_req, reg_vlp_req};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    n_checks++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs actual %b expected %b", tag, outs(), exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(input logic [2:0] code);
    mode_req = code;
    mode_go  = 1'b1;
    cyc(1);
    mode_go  = 1'b0;
    cyc(12);
  endtask

  task automatic back_to_run();
    irq_async = 1'b1;
    cyc(14);
    irq_async = 1'b0;
    cyc(6);
  endtask

  task automatic t_reset();
    check("R1 reset state", P_RUN);
    rst_n = 1'b1;
    cyc(4);
    check("R1 run after reset", P_RUN);
  endtask

  task automatic t_bad_code();
    enter(3'd5);
    check("R2 code 5 ignored", P_RUN);
    enter(3'd0);
    check("R2 code 0 ignored", P_RUN);
  endtask

  task automatic t_pstop_order();
    resp_bus_en = 1'b0;
    mode_req = 3'd2;
    mode_go  = 1'b1;
    cyc(1);
    mode_go  = 1'b0;
    cyc(5);
    check("R2 waits for master ack", P_MSTW);
    resp_bus_en = 1'b1;
    cyc(10);
    check("R3 partial stop settled", P_PSTOP);
    irq_async = 1'b1;
    cyc(2);
    check("R11 irq not seen within two edges", P_PSTOP);
    cyc(12);
    check("R6 irq exit from partial stop", P_RUN);
    irq_async = 1'b0;
    cyc(6);
  endtask

  task automatic t_stop_dma();
    enter(3'd3);
    check("R4 stop settled", P_STOP);
    dma_wake_en   = 4'b0101;
    dma_req_async = 4'b0010;
    cyc(12);
    check("R7 disabled channel ignored", P_STOP);
    resp_reg_en   = 1'b0;
    dma_req_async = 4'b0011;
    cyc(8);
    check("R8 regulator restored first", P_REGUP);
    resp_reg_en = 1'b1;
    dma_idle    = 1'b0;
    cyc(10);
    check("R8 dma wake core stays off", P_DMA);
    dma_req_async = 4'b0000;
    cyc(12);
    check("R9 waits for transfer completion", P_DMA);
    dma_idle = 1'b1;
    cyc(12);
    check("R9 re-entry into stop", P_STOP);
    back_to_run();
    check("R6 run after stop exit", P_RUN);
  endtask

  task automatic t_vlps();
    enter(3'd4);
    check("R4 very-low-power stop settled", P_VLPS);
    back_to_run();
    check("R6 irq exit from very-low-power stop", P_RUN);
  endtask

  task automatic t_compute();
    enter(3'd1);
    check("R5 compute settled", P_CMP);
    dma_req_async = 4'b0100;
    cyc(12);
    check("R8 compute dma wake keeps core on", P_RUN);
    dma_req_async = 4'b0000;
    cyc(12);
    check("R9 re-entry into compute", P_CMP);
    back_to_run();
  endtask

  task automatic t_irq_during_dma();
    enter(3'd2);
    dma_req_async = 4'b0001;
    cyc(12);
    check("R8 partial stop dma wake", P_DMA);
    irq_async = 1'b1;
    cyc(8);
    check("R10 irq during dma ends in run", P_RUN);
    irq_async = 1'b0;
    dma_req_async = 4'b0000;
    cyc(12);
    check("R10 stays in run", P_RUN);
  endtask

  task automatic t_reset_abort();
    enter(3'd4);
    rst_n = 1'b0;
    cyc(1);
    check("R1 reset aborts sleep", P_RUN);
    rst_n = 1'b1;
    cyc(4);
    check("R1 run after abort", P_RUN);
  endtask

  initial begin
    cyc(3);
    t_reset();
    t_bad_code();
    t_pstop_order();
    t_stop_dma();
    t_vlps();
    t_compute();
    t_irq_during_dma();
    t_reset_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule